// File: doc/BRIEF.md
# Serial Double-Buffered Synthesizer Register Bank

This block holds the control words for a two-loop frequency synthesizer and loads them from a three-wire serial port. A frame opens when the enable line goes high. While enable is high, one data bit is shifted in, most significant bit first, on each cycle that the shift qualifier is asserted. When enable drops, the frame closes. The number of bits received, together with an address field on long frames, selects which register the frame writes.

Most registers take effect as soon as their frame closes. Two holding registers act as shadows: one for the main-loop reference divider and one for the secondary-loop feedback divider. Their contents reach the working outputs only when the main-loop N register is written. That write commits both shadows and the N value in the same cycle, so the main reference, main N and secondary feedback change together. A one-cycle update vector marks each commit.

Top module: `synth_ctrl_regs`

## Requirements
- R1: Bits are shifted MSB first while `ser_en`=1 and `ser_shift`=1. A frame closes on the clock edge that samples `ser_en` low after it was high. Registers and `upd` change on the following edge, which is the second edge after the first low sample of `ser_en`.
- R2: An 8-bit frame writes `ctrl_q` immediately. The control fields are: `pd_float`=bit 4, `osc_stby`=bit 2, `loop_stby`=bits 1:0.
- R3: A 16-bit frame writes only the reference shadow register. No output and no `upd` bit changes.
- R4: A 32-bit frame carries the address in bits 27:24 and the payload in bits 23:0. Bits 31:28 are ignored. The addresses are: 0000 = main N, 0011 = DAC word, 0100 = feedback shadow, 0101 = secondary reference. A feedback-shadow write changes no output.
- R5: A main-N write also loads `main_ref_div` from the reference shadow and `sec_fb_q` from the feedback shadow, in the same cycle as `main_n_q`.
- R6: `sref_div` is `sref_q` bits 15:0 and `sref_refresh` is bits 19:17.
- R7: `main_ratio` is `main_n_q` bits 17:0 and `lock_win` is bit 22.
- R8: The following frames are discarded with no register change and no `upd` pulse: a frame whose length is not 8, 16 or 32 (including frames longer than 32 bits), and a 32-bit frame with any address not listed in R4.
- R9: A synchronous active-high `rst` clears every register and `upd` to zero.
- R10: `upd` pulses for exactly one cycle per commit. Its bits are: 0 = ctrl, 1 = DAC, 2 = secondary reference, 3 = main N, 4 = main reference, 5 = secondary feedback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | Frame enable; falling edge closes a frame |
| ser_shift | input | 1 | Shift qualifier, one bit per asserted cycle |
| ser_din | input | 1 | Serial data, MSB first |
| ctrl_q | output | 8 | Control register |
| pd_float | output | 1 | Main phase-detector outputs floated |
| osc_stby | output | 1 | Reference oscillator standby |
| loop_stby | output | 2 | Per-loop standby |
| main_ref_div | output | 16 | Main-loop reference divider (from shadow) |
| sref_q | output | 24 | Secondary reference-divider register |
| sref_div | output | 16 | Secondary reference divide value |
| sref_refresh | output | 3 | Multiplier refresh-rate code |
| main_n_q | output | 24 | Main-loop N register |
| main_ratio | output | 18 | Main-loop divide ratio |
| lock_win | output | 1 | Lock-detect window select |
| sec_fb_q | output | 24 | Secondary feedback divider (from shadow) |
| dac_q | output | 24 | DAC word register |
| upd | output | 6 | One-cycle commit strobes |

## Verification
A wrong bit counter or address decode sends a frame to the wrong destination. That shows up on the `upd` vector two edges after enable falls, as a wrong pulse or a missing pulse, before any later frame can hide it. A shadow that is lost, stale, or committed too early shows only at the next main-N write, so each shadow is loaded, then left alone across other frames, and its value is compared at that commit. Frames of rejected lengths, including ones longer than the shift register, must leave every output unchanged.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;
  localparam int FRAME_MAX = 32;
  localparam int CNT_W     = 6;
  localparam int PAY_W     = 24;
  localparam int CTRL_W    = 8;
  localparam int HR_W      = 16;
  localparam int UPD_W     = 6;

  localparam logic [3:0] ADDR_MAIN_N = 4'b0000;
  localparam logic [3:0] ADDR_DAC    = 4'b0011;
  localparam logic [3:0] ADDR_FB_SH  = 4'b0100;
  localparam logic [3:0] ADDR_SREF   = 4'b0101;

  typedef enum int {
    U_CTRL = 0, U_DAC = 1, U_SREF = 2, U_MAIN_N = 3, U_MREF = 4, U_SFB = 5
  } upd_idx_e;
endpackage

// File: rtl/ser_frame_rx.sv
module ser_frame_rx #(
  parameter int FW = 32,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          shift,
  input  logic          din,
  output logic          frm_vld,
  output logic [CW-1:0] frm_len,
  output logic [FW-1:0] frm_word
);
  logic          en_d;
  logic [CW-1:0] cnt;
  logic [FW-1:0] shreg;
  logic [CW-1:0] base;
  logic          opening;

  assign opening = en & ~en_d;
  assign base    = opening ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d     <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      frm_vld  <= 1'b0;
      frm_len  <= '0;
      frm_word <= '0;
    end else begin
      en_d    <= en;
      frm_vld <= 1'b0;
      if (en && shift) begin
        shreg <= {shreg[FW-2:0], din};
        cnt   <= (base == '1) ? base : base + 1'b1;
      end else if (opening) begin
        cnt <= '0;
      end
      if (!en && en_d) begin
        frm_vld  <= 1'b1;
        frm_len  <= cnt;
        frm_word <= shreg;
        cnt      <= '0;
      end
    end
  end
endmodule

// File: rtl/frame_decode.sv
module frame_decode
  import synth_ctrl_pkg::*;
#(
  parameter int FW = 32,
  parameter int CW = 6
) (
  input  logic          frm_vld,
  input  logic [CW-1:0] frm_len,
  input  logic [FW-1:0] frm_word,
  output logic          wr_ctrl,
  output logic          wr_hr,
  output logic          wr_hn,
  output logic          wr_sref,
  output logic          wr_dac,
  output logic          wr_n
);
  localparam int LEN_S = CTRL_W;
  localparam int LEN_M = HR_W;
  localparam int LEN_L = FW;

  logic       is_long;
  logic [3:0] addr;

  assign is_long = frm_vld && (frm_len == CW'(LEN_L));
  assign addr    = frm_word[PAY_W+3:PAY_W];

  always_comb begin
    wr_ctrl = frm_vld && (frm_len == CW'(LEN_S));
    wr_hr   = frm_vld && (frm_len == CW'(LEN_M));
    wr_n    = is_long && (addr == ADDR_MAIN_N);
    wr_dac  = is_long && (addr == ADDR_DAC);
    wr_hn   = is_long && (addr == ADDR_FB_SH);
    wr_sref = is_long && (addr == ADDR_SREF);
  end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import synth_ctrl_pkg::*;
#(
  parameter int FW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FW-1:0]     word,
  input  logic              wr_ctrl,
  input  logic              wr_hr,
  input  logic              wr_hn,
  input  logic              wr_sref,
  input  logic              wr_dac,
  input  logic              wr_n,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [HR_W-1:0]   mref_q,
  output logic [PAY_W-1:0]  sref_q,
  output logic [PAY_W-1:0]  main_n_q,
  output logic [PAY_W-1:0]  sfb_q,
  output logic [PAY_W-1:0]  dac_q,
  output logic [UPD_W-1:0]  upd
);
  logic [HR_W-1:0]  hr_sh;
  logic [PAY_W-1:0] hn_sh;
  logic [PAY_W-1:0] pay;

  assign pay = word[PAY_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      mref_q   <= '0;
      sref_q   <= '0;
      main_n_q <= '0;
      sfb_q    <= '0;
      dac_q    <= '0;
      hr_sh    <= '0;
      hn_sh    <= '0;
      upd      <= '0;
    end else begin
      upd <= '0;
      if (wr_ctrl) begin
        ctrl_q        <= word[CTRL_W-1:0];
        upd[U_CTRL]   <= 1'b1;
      end
      if (wr_hr) hr_sh <= word[HR_W-1:0];
      if (wr_hn) hn_sh <= pay;
      if (wr_dac) begin
        dac_q         <= pay;
        upd[U_DAC]    <= 1'b1;
      end
      if (wr_sref) begin
        sref_q        <= pay;
        upd[U_SREF]   <= 1'b1;
      end
      if (wr_n) begin
        main_n_q      <= pay;
        mref_q        <= hr_sh;
        sfb_q         <= hn_sh;
        upd[U_MAIN_N] <= 1'b1;
        upd[U_MREF]   <= 1'b1;
        upd[U_SFB]    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/synth_ctrl_regs.sv
module synth_ctrl_regs
  import synth_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_en,
  input  logic              ser_shift,
  input  logic              ser_din,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              pd_float,
  output logic              osc_stby,
  output logic [1:0]        loop_stby,
  output logic [HR_W-1:0]   main_ref_div,
  output logic [PAY_W-1:0]  sref_q,
  output logic [15:0]       sref_div,
  output logic [2:0]        sref_refresh,
  output logic [PAY_W-1:0]  main_n_q,
  output logic [17:0]       main_ratio,
  output logic              lock_win,
  output logic [PAY_W-1:0]  sec_fb_q,
  output logic [PAY_W-1:0]  dac_q,
  output logic [UPD_W-1:0]  upd
);
  logic                 frm_vld;
  logic [CNT_W-1:0]     frm_len;
  logic [FRAME_MAX-1:0] frm_word;
  logic wr_ctrl, wr_hr, wr_hn, wr_sref, wr_dac, wr_n;

  ser_frame_rx #(.FW(FRAME_MAX), .CW(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .en(ser_en), .shift(ser_shift), .din(ser_din),
    .frm_vld(frm_vld), .frm_len(frm_len), .frm_word(frm_word)
  );

  frame_decode #(.FW(FRAME_MAX), .CW(CNT_W)) u_dec (
    .frm_vld(frm_vld), .frm_len(frm_len), .frm_word(frm_word),
    .wr_ctrl(wr_ctrl), .wr_hr(wr_hr), .wr_hn(wr_hn),
    .wr_sref(wr_sref), .wr_dac(wr_dac), .wr_n(wr_n)
  );

  reg_bank #(.FW(FRAME_MAX)) u_bank (
    .clk(clk), .rst(rst), .word(frm_word),
    .wr_ctrl(wr_ctrl), .wr_hr(wr_hr), .wr_hn(wr_hn),
    .wr_sref(wr_sref), .wr_dac(wr_dac), .wr_n(wr_n),
    .ctrl_q(ctrl_q), .mref_q(main_ref_div), .sref_q(sref_q),
    .main_n_q(main_n_q), .sfb_q(sec_fb_q), .dac_q(dac_q), .upd(upd)
  );

  assign pd_float     = ctrl_q[4];
  assign osc_stby     = ctrl_q[2];
  assign loop_stby    = ctrl_q[1:0];
  assign sref_div     = sref_q[15:0];
  assign sref_refresh = sref_q[19:17];
  assign main_ratio   = main_n_q[17:0];
  assign lock_win     = main_n_q[22];
endmodule

// File: rtl/synth_ctrl_regs_chk.sv
module synth_ctrl_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  ctrl_q,
  input logic [15:0] main_ref_div,
  input logic [23:0] sref_q,
  input logic [23:0] sec_fb_q,
  input logic [5:0]  upd
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) (upd != 6'd0) |=> (upd == 6'd0)); // R10
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst) !upd[0] |-> $stable(ctrl_q)); // R2
  AST_MREF_HOLD: assert property (@(posedge clk) disable iff (rst) !upd[4] |-> $stable(main_ref_div)); // R3
  AST_SREF_HOLD: assert property (@(posedge clk) disable iff (rst) !upd[2] |-> $stable(sref_q)); // R4
  AST_SFB_HOLD: assert property (@(posedge clk) disable iff (rst) !upd[5] |-> $stable(sec_fb_q)); // R5
  AST_JOINT_COMMIT: assert property (@(posedge clk) disable iff (rst) upd[3] |-> (upd[4] && upd[5])); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (ctrl_q == 8'd0 && upd == 6'd0)); // R9
endmodule

bind synth_ctrl_regs synth_ctrl_regs_chk u_chk (
  .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .main_ref_div(main_ref_div),
  .sref_q(sref_q), .sec_fb_q(sec_fb_q), .upd(upd)
);

// File: tb/sim_synth_ctrl_regs.sv
module sim_synth_ctrl_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_en = 1'b0, ser_shift = 1'b0, ser_din = 1'b0;
  logic [7:0]  ctrl_q;
  logic        pd_float, osc_stby, lock_win;
  logic [1:0]  loop_stby;
  logic [15:0] main_ref_div, sref_div;
  logic [2:0]  sref_refresh;
  logic [17:0] main_ratio;
  logic [23:0] sref_q, main_n_q, sec_fb_q, dac_q;
  logic [5:0]  upd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [5:0] upd_early, upd_seen, upd_late;

  always #5 clk = ~clk;

  synth_ctrl_regs u0 (
    .clk(clk), .rst(rst), .ser_en(ser_en), .ser_shift(ser_shift), .ser_din(ser_din),
    .ctrl_q(ctrl_q), .pd_float(pd_float), .osc_stby(osc_stby), .loop_stby(loop_stby),
    .main_ref_div(main_ref_div), .sref_q(sref_q), .sref_div(sref_div),
    .sref_refresh(sref_refresh), .main_n_q(main_n_q), .main_ratio(main_ratio),
    .lock_win(lock_win), .sec_fb_q(sec_fb_q), .dac_q(dac_q), .upd(upd)
  );

  // entry: {len[6], word[32], exp_upd[6], sel[3], exp[24]}
  // sel: 0 ctrl, 1 dac, 2 sref, 3 main N, 4 main ref, 5 sec fb
  localparam int NV = 10;
  localparam logic [70:0] VEC [NV] = '{
    {6'd8,  32'h0000_0058, 6'b000001, 3'd0, 24'h000058},  // R2
    {6'd16, 32'h0000_1E60, 6'b000000, 3'd4, 24'h000000},  // R3
    {6'd32, 32'h0502_01E6, 6'b000100, 3'd2, 24'h0201E6},  // R4
    {6'd32, 32'h0400_1388, 6'b000000, 3'd5, 24'h000000},  // R4 shadow
    {6'd32, 32'h0081_5F90, 6'b111000, 3'd4, 24'h001E60},  // R5
    {6'd32, 32'hF3AB_CDEF, 6'b000010, 3'd1, 24'hABCDEF},  // R4 upper nibble ignored
    {6'd12, 32'h0000_0FFF, 6'b000000, 3'd0, 24'h000058},  // R8 length
    {6'd32, 32'h0712_3456, 6'b000000, 3'd2, 24'h0201E6},  // R8 address
    {6'd16, 32'h0000_1234, 6'b000000, 3'd4, 24'h001E60},  // R3
    {6'd32, 32'h0040_0100, 6'b111000, 3'd4, 24'h001234}   // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input logic [63:0] w);
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk);
      ser_en = 1'b1; ser_shift = 1'b1; ser_din = w[i];
    end
    @(negedge clk);
    ser_en = 1'b0; ser_shift = 1'b0; ser_din = 1'b0;
    @(negedge clk); upd_early = upd;
    @(negedge clk); upd_seen = upd;
    @(negedge clk); upd_late = upd;
  endtask

  function automatic logic [23:0] pick(input logic [2:0] s);
    case (s)
      3'd0: pick = {16'd0, ctrl_q};
      3'd1: pick = dac_q;
      3'd2: pick = sref_q;
      3'd3: pick = main_n_q;
      3'd4: pick = {8'd0, main_ref_div};
      default: pick = sec_fb_q;
    endcase
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 ctrl", {24'd0, ctrl_q}, 0);
    check("R9 n", {8'd0, main_n_q}, 0);
    check("R9 upd", {26'd0, upd}, 0);

    for (int k = 0; k < NV; k++) begin
      send_frame(int'(VEC[k][70:65]), {32'd0, VEC[k][64:33]});
      check("R1 no early commit", {26'd0, upd_early}, 0);
      check("R10 strobe", {26'd0, upd_seen}, {26'd0, VEC[k][32:27]});
      check("R10 one cycle", {26'd0, upd_late}, 0);
      check("R2/R3/R4/R5/R8 value", {8'd0, pick(VEC[k][26:24])}, {8'd0, VEC[k][23:0]});
    end

    // R5 feedback shadow committed and kept; R7 N fields
    check("R5 sec fb", {8'd0, sec_fb_q}, 32'h001388);
    check("R7 ratio", {14'd0, main_ratio}, 32'h100);
    check("R7 lock_win", {31'd0, lock_win}, 1);
    // R2 control fields from 0x13 after the next frame
    send_frame(8, 64'h13);
    check("R2 ctrl", {24'd0, ctrl_q}, 32'h13);
    check("R2 pd_float", {31'd0, pd_float}, 1);
    check("R2 osc_stby", {31'd0, osc_stby}, 0);
    check("R2 loop_stby", {30'd0, loop_stby}, 3);
    // R6 secondary reference fields
    check("R6 div", {16'd0, sref_div}, 32'h01E6);
    check("R6 refresh", {29'd0, sref_refresh}, 1);
    // R8 over-long frame (40 bits) whose tail looks like a control write
    send_frame(40, 64'h00_0000_0077);
    check("R8 long upd", {26'd0, upd_seen}, 0);
    check("R8 long ctrl", {24'd0, ctrl_q}, 32'h13);
    // R1 MSB-first order: a 16-bit shadow value committed through main N
    send_frame(16, 64'h8001);
    send_frame(32, 64'h0000_0005);
    check("R1 msb first", {16'd0, main_ref_div}, 32'h8001);
    check("R1 n payload", {8'd0, main_n_q}, 32'h5);
    // R9 mid-run reset
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R9 ctrl", {24'd0, ctrl_q}, 0);
    check("R9 mref", {16'd0, main_ref_div}, 0);
    check("R9 sref", {8'd0, sref_q}, 0);
    check("R9 sfb", {8'd0, sec_fb_q}, 0);
    check("R9 dac", {8'd0, dac_q}, 0);
    // R9 shadows cleared too: commit after reset yields zeros
    send_frame(32, 64'h0000_0001);
    check("R9 mref shadow", {16'd0, main_ref_div}, 0);
    check("R9 sfb shadow", {8'd0, sec_fb_q}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule